// File: doc/BRIEF.md
# DRAM Page-Close and Refresh Scheduler

This block decides, cycle by cycle, what a page-mode DRAM sequencer does next. The array has two interleaved banks. Each bank can hold one open row. The scheduler keeps a valid flag and the open row for each bank. It classifies each processor request as a page hit, a page miss on an empty bank, or a row conflict. For each case it issues the matching sequence of close, open and column-access commands. Every command is a one-cycle strobe. The scheduler then waits for the sequencer's done pulse before it issues the next command.

Refresh comes from a free-running interval counter. Its period is chosen from four rates scaled by a clocks-per-microsecond parameter. Before a refresh strobe goes out, every open bank is closed. Each bank also has a timer that restarts on every open or access of that bank. When automatic closing is enabled and the page has stayed open for 10 µs, the timer forces the page closed. When automatic closing is disabled, only refresh bounds how long a page stays open. The processor sees refresh only as wait states. A request that meets a due refresh waits until the refresh has finished. A refresh that falls due during an access is served once that access completes, before the next request.

Top module: `dram_refresh_page_sched`

## Requirements
- R1: With `rate_sel` = 0, 1, 2 or 3, consecutive `refresh_stb` pulses are spaced C·125/8, C·125/2, C·125 and C·250 clock cycles apart respectively, where C is `CYC_PER_US`. This holds when no open page has to be closed first and the sequencer answers within one period.
- R2: Every open bank receives a `close_stb`, lowest bank first, before `refresh_stb` is issued. After the refresh, the next request to either bank is a page miss.
- R3: A request to a bank that is open on the requested row produces a single `acc_stb` with `page_hit`=1, with no close or open in between.
- R4: A request to a bank with no open page produces `open_stb` carrying the requested row on `cmd_row`, then `acc_stb` with `page_miss`=1.
- R5: A request to a bank that is open on a different row produces `close_stb` for that bank, then `open_stb` for the new row, then `acc_stb` with `page_miss`=1.
- R6: The two banks keep their open rows independently. Opening a row in one bank leaves the other bank's page open and hitting.
- R7: With `auto_close_en`=1 and no other activity, a bank's `close_stb` appears exactly 10·C+1 cycles after its last `acc_stb`.
- R8: Each access to an open page restarts that bank's 10 µs timer.
- R9: With `auto_close_en`=0, an open page gets no `close_stb` before the next refresh unless a request conflicts with it.
- R10: A request made while a refresh is due or in progress keeps `proc_wait` high until the refresh has finished. Its `acc_stb` follows the `refresh_stb`.
- R11: A refresh that falls due during an access is deferred until that access completes. It is then served, starting with its page closes, before the next waiting request.
- R12: `proc_wait` equals `req_valid`, except that it is 0 in the cycle where `seq_done` completes that request's access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request, held until accepted |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| rate_sel | input | 2 | Refresh rate select (0 fastest, 3 slowest) |
| auto_close_en | input | 1 | Enables the 10 µs page watchdog |
| seq_done | input | 1 | Sequencer finished the last command |
| close_stb | output | 1 | Precharge command for `cmd_bank` |
| open_stb | output | 1 | Activate command for `cmd_bank`, row `cmd_row` |
| acc_stb | output | 1 | Column access for `cmd_bank` |
| refresh_stb | output | 1 | Refresh command |
| cmd_bank | output | BANK_W | Bank of the current command |
| cmd_row | output | ROW_W | Row stored for `cmd_bank` |
| page_hit | output | 1 | With `acc_stb`: the request hit an open page |
| page_miss | output | 1 | With `acc_stb`: the request needed an open |
| proc_wait | output | 1 | Processor wait state |

## Verification
If a bank's valid flag or stored row is corrupted, the next request to that bank shows the wrong command sequence. It appears within a few cycles: an extra or missing `open_stb`, or an inverted hit/miss flag. A wrong page timer shows up in the exact distance from the last access to the forced close, and the bench measures that distance to the cycle. A broken refresh counter or a lost pending flag shifts the spacing of `refresh_stb`, lets an access slip ahead of a due refresh, or leaves a page open across a refresh. Each of these is visible in the order and timing of strobes within one refresh period.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } sched_state_e;

    typedef enum logic [1:0] {
        K_CLOSE,
        K_OPEN,
        K_ACCESS,
        K_REFRESH
    } cmd_kind_e;

    // Refresh period in clocks for a rate selection.
    function automatic int unsigned refresh_period(input int unsigned cyc_per_us,
                                                   input logic [1:0] sel);
        int unsigned p;
        case (sel)
            2'd0:    p = (cyc_per_us * 125) / 8;
            2'd1:    p = (cyc_per_us * 125) / 2;
            2'd2:    p = cyc_per_us * 125;
            default: p = cyc_per_us * 250;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dps_refresh_gen.sv
module dps_refresh_gen
    import dps_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    output logic       due_o
);
    localparam int unsigned MAX_P = CYC_PER_US * 250;
    localparam int unsigned CNT_W = $clog2(MAX_P + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] period;

    always_comb begin
        period = CNT_W'(refresh_period(CYC_PER_US, rate_sel));
        due_o  = (cnt_q >= period - 1'b1);
        cnt_d  = due_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MAX_P));

endmodule

// File: rtl/dps_page_timer.sv
module dps_page_timer #(
    parameter int unsigned LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired_o = (cnt_q == CNT_W'(LIMIT));
        if (restart_i)      cnt_d = '0;
        else if (expired_o) cnt_d = cnt_q;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Once expired, the timer stays expired until restarted (R7).
    a_r7_expiry_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !restart_i) |=> expired_o);

    // A restart clears the expiry on the next cycle (R8).
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !expired_o);

endmodule

// File: rtl/dram_refresh_page_sched.sv
module dram_refresh_page_sched
    import dps_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 50,
    parameter int unsigned ROW_W      = 12,
    parameter int unsigned BANK_W     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [1:0]        rate_sel,
    input  logic              auto_close_en,
    input  logic              seq_done,
    output logic              close_stb,
    output logic              open_stb,
    output logic              acc_stb,
    output logic              refresh_stb,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic              page_hit,
    output logic              page_miss,
    output logic              proc_wait
);
    localparam int unsigned NB     = 1 << BANK_W;
    localparam int unsigned AC_CYC = CYC_PER_US * 10;

    typedef struct packed {
        sched_state_e                st;
        cmd_kind_e                   kind;
        logic [BANK_W-1:0]           bank;
        logic                        busy;
        logic                        miss;
        logic                        pend;
        logic [NB-1:0]               vld;
        logic [NB-1:0][ROW_W-1:0]    rows;
        logic                        close_stb;
        logic                        open_stb;
        logic                        acc_stb;
        logic                        ref_stb;
        logic                        hit;
        logic                        pmiss;
    } sched_t;

    sched_t        d, q;
    logic          ref_due;
    logic          ref_now;
    logic [NB-1:0] expired;
    logic [NB-1:0] restart;

    function automatic logic [BANK_W-1:0] lowest(input logic [NB-1:0] v);
        logic [BANK_W-1:0] idx;
        idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (v[i]) idx = BANK_W'(i);
        end
        return idx;
    endfunction

    dps_refresh_gen #(.CYC_PER_US(CYC_PER_US)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .due_o    (ref_due)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        dps_page_timer #(.LIMIT(AC_CYC)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart[g]),
            .expired_o (expired[g])
        );
    end

    always_comb begin
        d           = q;
        d.close_stb = 1'b0;
        d.open_stb  = 1'b0;
        d.acc_stb   = 1'b0;
        d.ref_stb   = 1'b0;
        d.hit       = 1'b0;
        d.pmiss     = 1'b0;
        restart     = '0;
        ref_now     = q.pend | ref_due;
        if (ref_due) d.pend = 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (q.busy && !req_valid) begin
                    d.busy = 1'b0;
                    d.miss = 1'b0;
                end
                if (ref_now && !q.busy) begin
                    d.st = ST_WAIT;
                    if (|q.vld) begin
                        d.kind      = K_CLOSE;
                        d.bank      = lowest(q.vld);
                        d.close_stb = 1'b1;
                    end else begin
                        d.kind    = K_REFRESH;
                        d.ref_stb = 1'b1;
                    end
                end else if (!q.busy && auto_close_en && |(q.vld & expired)) begin
                    d.st        = ST_WAIT;
                    d.kind      = K_CLOSE;
                    d.bank      = lowest(q.vld & expired);
                    d.close_stb = 1'b1;
                end else if (req_valid) begin
                    d.st   = ST_WAIT;
                    d.bank = req_bank;
                    if (q.vld[req_bank] && q.rows[req_bank] == req_row) begin
                        d.kind             = K_ACCESS;
                        d.acc_stb          = 1'b1;
                        d.hit              = !q.miss;
                        d.pmiss            = q.miss;
                        d.busy             = 1'b1;
                        restart[req_bank]  = 1'b1;
                    end else if (q.vld[req_bank]) begin
                        d.kind      = K_CLOSE;
                        d.close_stb = 1'b1;
                        d.busy      = 1'b1;
                        d.miss      = 1'b1;
                    end else begin
                        d.kind             = K_OPEN;
                        d.open_stb         = 1'b1;
                        d.rows[req_bank]   = req_row;
                        d.busy             = 1'b1;
                        d.miss             = 1'b1;
                        restart[req_bank]  = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (seq_done) begin
                    d.st = ST_IDLE;
                    case (q.kind)
                        K_CLOSE:   d.vld[q.bank] = 1'b0;
                        K_OPEN:    d.vld[q.bank] = 1'b1;
                        K_ACCESS: begin
                            d.busy = 1'b0;
                            d.miss = 1'b0;
                        end
                        default:   if (!ref_due) d.pend = 1'b0;
                    endcase
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign close_stb   = q.close_stb;
    assign open_stb    = q.open_stb;
    assign acc_stb     = q.acc_stb;
    assign refresh_stb = q.ref_stb;
    assign cmd_bank    = q.bank;
    assign cmd_row     = q.rows[q.bank];
    assign page_hit    = q.hit;
    assign page_miss   = q.pmiss;
    assign proc_wait   = req_valid &&
                         !(q.st == ST_WAIT && q.kind == K_ACCESS && seq_done);

    // At most one command strobe per cycle (R1, R5).
    a_r5_one_command: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({close_stb, open_stb, acc_stb, refresh_stb}));

    // Refresh is only issued with no page open (R2).
    a_r2_refresh_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb |-> (q.vld == '0));

    // Hit and miss flags travel only with an access, never both (R3, R4).
    a_r3_flags_with_access: assert property (@(posedge clk) disable iff (!rst_n)
        (page_hit || page_miss) |-> (acc_stb && !(page_hit && page_miss)));

    // An access always targets an open bank (R4).
    a_r4_access_on_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |-> q.vld[cmd_bank]);

    // With a refresh owed and no access in flight, no access or open follows (R10).
    a_r10_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && q.pend && !q.busy) |=> !(acc_stb || open_stb));

    // No wait state without a request (R12).
    a_r12_wait_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !proc_wait);

endmodule

// File: tb/dram_refresh_page_sched_tb.sv
module dram_refresh_page_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int C          = 8;
    localparam int ROW_W      = 4;
    localparam int BANK_W     = 1;
    localparam int AC_GAP     = 10 * C + 1;
    localparam int LOG_N      = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [1:0]        rate_sel = 2'd3;
    logic              auto_close_en = 1'b0;
    logic              seq_done = 1'b0;
    logic              close_stb, open_stb, acc_stb, refresh_stb;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic              page_hit, page_miss, proc_wait;

    dram_refresh_page_sched #(
        .CYC_PER_US(C), .ROW_W(ROW_W), .BANK_W(BANK_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .rate_sel(rate_sel), .auto_close_en(auto_close_en),
        .seq_done(seq_done), .close_stb(close_stb), .open_stb(open_stb),
        .acc_stb(acc_stb), .refresh_stb(refresh_stb), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .page_hit(page_hit), .page_miss(page_miss),
        .proc_wait(proc_wait)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Event log: kind 0 close, 1 open, 2 access, 3 refresh.
    int ev_kind [LOG_N];
    int ev_bank [LOG_N];
    int ev_row  [LOG_N];
    int ev_hit  [LOG_N];
    int ev_miss [LOG_N];
    int ev_cyc  [LOG_N];
    int ev_n = 0;

    int base_lat = 2;
    int acc_lat  = 2;
    int rsp_cnt  = 0;

    int last_hit, last_miss, last_acc_idx, last_wait;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Sequencer model and command monitor.
    always @(negedge clk) begin
        seq_done = 1'b0;
        if (rsp_cnt != 0) begin
            rsp_cnt = rsp_cnt - 1;
            if (rsp_cnt == 0) seq_done = 1'b1;
        end
        if (close_stb || open_stb || refresh_stb) rsp_cnt = base_lat;
        if (acc_stb) rsp_cnt = acc_lat;
        if ((close_stb || open_stb || acc_stb || refresh_stb) && ev_n < LOG_N) begin
            ev_kind[ev_n] = close_stb ? 0 : open_stb ? 1 : acc_stb ? 2 : 3;
            ev_bank[ev_n] = int'(cmd_bank);
            ev_row[ev_n]  = int'(cmd_row);
            ev_hit[ev_n]  = int'(page_hit);
            ev_miss[ev_n] = int'(page_miss);
            ev_cyc[ev_n]  = cyc;
            ev_n++;
        end
    end

    function automatic int find_next(input int from, input int kind, input int bank);
        for (int i = from; i < ev_n; i++) begin
            if (ev_kind[i] == kind && (bank < 0 || ev_bank[i] == bank)) return i;
        end
        return -1;
    endfunction

    function automatic int count_kind(input int from, input int to, input int kind);
        int n = 0;
        for (int i = from; i < to; i++) if (ev_kind[i] == kind) n++;
        return n;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Processor request; also checks R12 at the release cycle.
    task automatic do_req(input int b, input int r);
        int s;
        @(negedge clk);
        #1;
        s         = ev_n;
        req_valid = 1'b1;
        req_bank  = BANK_W'(b);
        req_row   = ROW_W'(r);
        last_wait = 0;
        forever begin
            @(negedge clk);
            #1;
            if (!proc_wait) break;
            last_wait++;
        end
        chk(seq_done == 1'b1, "R12", "wait drops only with access done", seq_done, 1);
        req_valid    = 1'b0;
        last_acc_idx = -1;
        for (int i = ev_n - 1; i >= s; i--) begin
            if (ev_kind[i] == 2) begin
                last_acc_idx = i;
                break;
            end
        end
        if (last_acc_idx >= 0) begin
            last_hit  = ev_hit[last_acc_idx];
            last_miss = ev_miss[last_acc_idx];
        end else begin
            last_hit  = -1;
            last_miss = -1;
        end
    endtask

    task automatic wait_ref(output int idx);
        int s = ev_n;
        idx = -1;
        while (idx < 0) begin
            @(negedge clk);
            #2;
            idx = find_next(s, 3, -1);
        end
    endtask

    initial begin
        int ri, i0, i1, a1, a2, a3, s, c0, c1, rr;

        idle(5);
        #1 rst_n = 1'b1;
        // Reset state
        #1;
        chk(!close_stb && !open_stb && !acc_stb && !refresh_stb, "R1",
            "no strobe after reset", {close_stb, open_stb, acc_stb, refresh_stb}, 0);
        chk(!proc_wait && !page_hit && !page_miss, "R12", "quiet outputs after reset",
            {proc_wait, page_hit, page_miss}, 0);

        wait_ref(ri);

        // R4: empty bank
        s = ev_n;
        do_req(0, 5);
        chk(last_miss == 1 && last_hit == 0, "R4", "empty bank miss", last_miss, 1);
        i0 = find_next(s, 1, 0);
        chk(i0 >= 0 && i0 < last_acc_idx, "R4", "open before access", i0, s);
        chk(i0 >= 0 && ev_row[i0] == 5, "R4", "open row", (i0 >= 0) ? ev_row[i0] : -1, 5);

        // R3: hit
        s = ev_n;
        do_req(0, 5);
        chk(last_hit == 1 && last_miss == 0, "R3", "hit flag", last_hit, 1);
        chk(ev_n - s == 1, "R3", "single access command", ev_n - s, 1);

        // R5: conflict
        s = ev_n;
        do_req(0, 9);
        chk(ev_n - s == 3 && ev_kind[s] == 0 && ev_kind[s+1] == 1 && ev_kind[s+2] == 2,
            "R5", "close-open-access order", ev_n - s, 3);
        chk(last_miss == 1, "R5", "conflict miss", last_miss, 1);
        chk(ev_row[s+1] == 9, "R5", "new row opened", ev_row[s+1], 9);

        // R6: second bank independent
        do_req(1, 5);
        chk(last_miss == 1, "R6", "bank1 first miss", last_miss, 1);
        s = ev_n;
        do_req(0, 9);
        chk(last_hit == 1 && ev_n - s == 1, "R6", "bank0 still open", last_hit, 1);
        do_req(1, 5);
        chk(last_hit == 1, "R6", "bank1 still open", last_hit, 1);

        // R7 / R8: watchdog close
        wait_ref(ri);
        auto_close_en = 1'b1;
        do_req(0, 3);
        a1 = ev_cyc[last_acc_idx];
        s  = ev_n;
        idle(40);
        do_req(0, 3);
        chk(last_hit == 1, "R8", "hit after 40 cycles", last_hit, 1);
        a2 = ev_cyc[last_acc_idx];
        do_req(1, 6);
        a3 = ev_cyc[last_acc_idx];
        idle(120);
        c0 = find_next(s, 0, 0);
        c1 = find_next(s, 0, 1);
        chk(c0 >= 0 && ev_cyc[c0] - a2 == AC_GAP, "R8", "bank0 close timed from last access",
            (c0 >= 0) ? ev_cyc[c0] - a2 : -1, AC_GAP);
        chk(c0 >= 0 && ev_cyc[c0] - a1 > AC_GAP, "R8", "no close from first access",
            (c0 >= 0) ? ev_cyc[c0] - a1 : -1, a2 - a1 + AC_GAP);
        chk(c1 >= 0 && ev_cyc[c1] - a3 == AC_GAP, "R7", "bank1 close gap",
            (c1 >= 0) ? ev_cyc[c1] - a3 : -1, AC_GAP);
        do_req(0, 3);
        chk(last_miss == 1, "R7", "miss after watchdog close", last_miss, 1);
        auto_close_en = 1'b0;

        // R9: watchdog off
        do_req(1, 2);
        s = ev_n;
        idle(300);
        chk(count_kind(s, ev_n, 0) == 0, "R9", "no close with watchdog off",
            count_kind(s, ev_n, 0), 0);
        do_req(0, 3);
        chk(last_hit == 1, "R9", "bank0 page survives", last_hit, 1);

        // R2: refresh closes pages
        wait_ref(ri);
        chk(ri >= 2 && ev_kind[ri-2] == 0 && ev_bank[ri-2] == 0 &&
            ev_kind[ri-1] == 0 && ev_bank[ri-1] == 1, "R2", "closes precede refresh",
            (ri >= 2) ? ev_kind[ri-1] : -1, 0);
        do_req(0, 3);
        chk(last_miss == 1, "R2", "bank0 miss after refresh", last_miss, 1);
        do_req(1, 2);
        chk(last_miss == 1, "R2", "bank1 miss after refresh", last_miss, 1);

        // R10: request during refresh
        forever begin
            @(negedge clk);
            #2;
            if (refresh_stb) break;
        end
        rr = ev_n - 1;
        do_req(1, 2);
        chk(last_wait >= 2, "R10", "wait states during refresh", last_wait, 2);
        chk(last_acc_idx > rr && ev_cyc[last_acc_idx] > ev_cyc[rr], "R10",
            "access after refresh", ev_cyc[last_acc_idx], ev_cyc[rr] + 1);
        chk(last_miss == 1, "R10", "page closed by refresh", last_miss, 1);

        // R11: refresh due during long access
        rate_sel = 2'd0;
        wait_ref(ri);
        acc_lat = 150;
        do_req(0, 4);
        i0 = last_acc_idx;
        do_req(1, 7);
        i1 = last_acc_idx;
        chk(i0 + 1 < ev_n && (ev_kind[i0+1] == 0 || ev_kind[i0+1] == 3), "R11",
            "refresh work follows access", ev_kind[i0+1], 0);
        chk(count_kind(i0 + 1, i1, 3) >= 1, "R11", "refresh before next access",
            count_kind(i0 + 1, i1, 3), 1);
        acc_lat = 2;

        // R1: interval sweep
        for (int sel = 0; sel < 4; sel++) begin
            int e1, e2, e3, exp_p;
            rate_sel = 2'(sel);
            exp_p = (sel == 0) ? (C * 125) / 8 : (sel == 1) ? (C * 125) / 2 :
                    (sel == 2) ? C * 125 : C * 250;
            wait_ref(e1);
            wait_ref(e2);
            wait_ref(e3);
            chk(ev_cyc[e3] - ev_cyc[e2] == exp_p, "R1", $sformatf("period sel=%0d", sel),
                ev_cyc[e3] - ev_cyc[e2], exp_p);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule